// File: doc/BRIEF.md
# Configurable CPU Interrupt Controller

This block sits inside a processor and gathers up to 32 external interrupt lines into one request signal for the core. Each line owns one bit in an enable (mask) register and one bit, at the same position, in a pending (status) register. Whenever some pending bit is also enabled, the request to the core is raised one clock later. Software reaches both registers through a small special-register port: one select bit picks the register, a write strobe stores data, and the selected register is always visible on the read bus.

The trigger behaviour is fixed when the block is built and applies to every line alike. In level mode the pending bits simply follow the inputs. In edge mode a rising input sets a pending bit, and that bit stays set until software writes 1 to it. In legacy mode the inputs are latched like edges, even when they are levels, and software clears a bit by writing 0 to it. Legacy software clears with a read-modify-write, so every bit written as 1 must keep its pending state.

Top module: `ictl_core`

## Requirements
- R1: After reset the mask register, the status register and `irq_req` are all 0, in every mode.
- R2: A write with `reg_sel`=0 stores `reg_wdata` into the mask register (bit i enables line i, 1 = enabled). It reads back on `reg_rdata` while `reg_sel`=0.
- R3: `irq_req` is 1 in the cycle after one in which some bit i has status[i]=1 and mask[i]=1, and it is 0 in the cycle after one in which no such bit exists.
- R4: With `reg_sel`=1, `reg_rdata` shows the status register. A pending bit is visible there even while its mask bit is 0, and in that case it raises no request.
- R5: Level mode (MODE=0): each status bit equals its input line as sampled at the previous clock edge. Status writes have no effect: a line that stays high reads back 1 after a write of all ones.
- R6: Edge mode (MODE=1): an input that was 0 at one clock edge and is 1 at the next sets its status bit. The bit stays 1 after the input falls, until it is cleared.
- R7: Edge mode: a write with `reg_sel`=1 clears each status bit whose data bit is 1 and leaves every bit written as 0 unchanged.
- R8: Edge mode: if a new rising edge and a clearing write for the same line fall in the same cycle, the status bit ends up set.
- R9: Legacy mode (MODE=2): an input seen high at a clock edge sets its status bit, and the bit stays 1 after the input returns low.
- R10: Legacy mode: a status write clears each bit whose data bit is 0 and leaves every bit written as 1 unchanged. A line that is still high reads back as pending after its clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | NUM_LINES | Interrupt inputs, bit i is line i |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 1 | Register select: 0 = mask, 1 = status |
| reg_wdata | input | NUM_LINES | Write data |
| reg_rdata | output | NUM_LINES | Contents of the selected register |
| irq_req | output | 1 | Registered interrupt request to the core |

## Verification
The properties assume that the interrupt inputs are synchronous to `clk` and stable around its rising edge, and that the lines are low while reset is held, so that no edge can appear at the first edge after reset. The bench drives every input on the falling edge and holds all lines low during each reset pulse. The bench also writes the mask and the status registers only through single-cycle strobes. Writing with `reg_sel` changing in mid-cycle is never exercised.

// File: rtl/ictl_pkg.sv
package ictl_pkg;

  typedef enum logic [1:0] {
    TRIG_LEVEL  = 2'd0,
    TRIG_EDGE   = 2'd1,
    TRIG_LEGACY = 2'd2
  } trig_mode_e;

  localparam int unsigned SEL_MASK   = 0;
  localparam int unsigned SEL_STATUS = 1;

endpackage

// File: rtl/ictl_capture.sv
module ictl_capture
  import ictl_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter trig_mode_e  MODE      = TRIG_EDGE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines,
  output logic [NUM_LINES-1:0] set_vec
);

  function automatic logic [NUM_LINES-1:0] rise_of(
    input logic [NUM_LINES-1:0] now_v,
    input logic [NUM_LINES-1:0] old_v
  );
    return now_v & ~old_v;
  endfunction

  generate
    if (MODE == TRIG_EDGE) begin : g_edge
      logic [NUM_LINES-1:0] prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lines;
      end

      assign set_vec = rise_of(lines, prev_q);

      // R6: a set request for a line means that line was low one edge earlier
      a_r6_rise_from_low: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((set_vec & $past(lines)) == '0));
    end else begin : g_level
      assign set_vec = lines;
    end
  endgenerate

endmodule

// File: rtl/ictl_status.sv
module ictl_status
  import ictl_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter trig_mode_e  MODE      = TRIG_EDGE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] set_vec,
  input  logic                 wr_stb,
  input  logic [NUM_LINES-1:0] wr_data,
  output logic [NUM_LINES-1:0] status_q
);

  function automatic logic [NUM_LINES-1:0] clear_bits(
    input logic                 stb,
    input logic [NUM_LINES-1:0] d,
    input logic                 inv
  );
    if (!stb) return '0;
    return inv ? ~d : d;
  endfunction

  generate
    if (MODE == TRIG_LEVEL) begin : g_follow
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= set_vec;
      end
    end else begin : g_latch
      localparam bit INV_POL = (MODE == TRIG_LEGACY);
      logic [NUM_LINES-1:0] clr_vec;
      logic [NUM_LINES-1:0] keep_vec;

      assign clr_vec  = clear_bits(wr_stb, wr_data, INV_POL);
      assign keep_vec = ~clr_vec;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & keep_vec) | set_vec;
      end

      // R6 / R9: without a write, no pending bit is lost
      a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> ((status_q & $past(status_q)) == $past(status_q)));

      // R8: a set request wins over a clear in the same cycle
      a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

      if (INV_POL) begin : g_inv_chk
        // R10: bits written as 1 keep their pending state
        a_r10_legacy_keep: assert property (@(posedge clk) disable iff (!rst_n)
          wr_stb |=> ((status_q & $past(status_q & wr_data)) == $past(status_q & wr_data)));
      end else begin : g_std_chk
        // R7: bits written as 0 keep their pending state
        a_r7_edge_keep: assert property (@(posedge clk) disable iff (!rst_n)
          wr_stb |=> ((status_q & $past(status_q & ~wr_data)) == $past(status_q & ~wr_data)));
      end
    end
  endgenerate

endmodule

// File: rtl/ictl_mask.sv
module ictl_mask #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic [NUM_LINES-1:0] wr_data,
  output logic [NUM_LINES-1:0] mask_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '0;
    else if (wr_stb) mask_q <= wr_data;
  end

  // R2: a mask write is visible at the next edge
  a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (mask_q == $past(wr_data)));

  // R2: the mask does not change without a write
  a_r2_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(mask_q));

endmodule

// File: rtl/ictl_request.sv
module ictl_request #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] status_v,
  input  logic [NUM_LINES-1:0] mask_v,
  output logic                 irq_req
);

  function automatic logic any_enabled(
    input logic [NUM_LINES-1:0] st,
    input logic [NUM_LINES-1:0] mk
  );
    return |(st & mk);
  endfunction

  logic want_irq;
  assign want_irq = any_enabled(status_v, mask_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_req <= 1'b0;
    else        irq_req <= want_irq;
  end

  // R3: a raised request always has an enabled pending line behind it
  a_r3_req_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(|(status_v & mask_v)));

  // R4: pending bits whose mask is 0 never raise the request
  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_v & mask_v) == '0) |=> !irq_req);

endmodule

// File: rtl/ictl_core.sv
module ictl_core
  import ictl_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter trig_mode_e  MODE      = TRIG_EDGE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 reg_wr,
  input  logic                 reg_sel,
  input  logic [NUM_LINES-1:0] reg_wdata,
  output logic [NUM_LINES-1:0] reg_rdata,
  output logic                 irq_req
);

  logic [NUM_LINES-1:0] set_vec;
  logic [NUM_LINES-1:0] status_q;
  logic [NUM_LINES-1:0] mask_q;
  logic                 status_wr;
  logic                 mask_wr;

  assign status_wr = reg_wr && (reg_sel == 1'(SEL_STATUS));
  assign mask_wr   = reg_wr && (reg_sel == 1'(SEL_MASK));

  ictl_capture #(.NUM_LINES(NUM_LINES), .MODE(MODE)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines   (irq_lines),
    .set_vec (set_vec)
  );

  ictl_status #(.NUM_LINES(NUM_LINES), .MODE(MODE)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .wr_stb   (status_wr),
    .wr_data  (reg_wdata),
    .status_q (status_q)
  );

  ictl_mask #(.NUM_LINES(NUM_LINES)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (mask_wr),
    .wr_data (reg_wdata),
    .mask_q  (mask_q)
  );

  ictl_request #(.NUM_LINES(NUM_LINES)) u_request (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_v (status_q),
    .mask_v   (mask_q),
    .irq_req  (irq_req)
  );

  assign reg_rdata = (reg_sel == 1'(SEL_STATUS)) ? status_q : mask_q;

  generate
    if (MODE == TRIG_LEVEL) begin : g_lvl_chk
      // R5: status mirrors the lines sampled at the previous edge
      a_r5_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_q == $past(irq_lines)));
    end else begin : g_lat_chk
      // R9 / R6: a line high at an edge without prior level is caught
      a_r9_line_caught: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == TRIG_LEGACY && |irq_lines) |=> ((status_q & $past(irq_lines)) == $past(irq_lines)));
    end
  endgenerate

endmodule

// File: tb/sim_ictl_core.sv
module sim_ictl_core;
  import ictl_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_lines = '0;
  logic         reg_wr = 1'b0;
  logic         reg_sel = 1'b0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] rd0, rd1, rd2;
  logic         irq0, irq1, irq2;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ictl_core #(.NUM_LINES(N), .MODE(TRIG_LEVEL)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(rd0), .irq_req(irq0));
  ictl_core #(.NUM_LINES(N), .MODE(TRIG_EDGE)) u1 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(rd1), .irq_req(irq1));
  ictl_core #(.NUM_LINES(N), .MODE(TRIG_LEGACY)) u2 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(rd2), .irq_req(irq2));

  // level-mode vectors: {lines, mask}
  localparam logic [63:0] LVL_VEC [6] = '{
    {32'h0000_0000, 32'hFFFF_FFFF},
    {32'h0000_0001, 32'h0000_0001},
    {32'h8000_0000, 32'h7FFF_FFFF},
    {32'h8000_0000, 32'h8000_0000},
    {32'h0F0F_0000, 32'h0000_F0F0},
    {32'hDEAD_BEEF, 32'h0000_0100}
  };

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_reg(input logic sel, input logic [N-1:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_reset();
    irq_lines = '0; reg_wr = 1'b0;
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  function automatic logic [N-1:0] b(input int i);
    return N'(1) << i;
  endfunction

  initial begin
    do_reset();
    // R1: reset state of all three variants
    reg_sel = 1'b0; #1;
    chk("R1 mask lvl", rd0, '0); chk("R1 mask edge", rd1, '0); chk("R1 mask legacy", rd2, '0);
    reg_sel = 1'b1; #1;
    chk("R1 status lvl", rd0, '0); chk("R1 status edge", rd1, '0); chk("R1 status legacy", rd2, '0);
    chk("R1 irq", {29'd0, irq0, irq1, irq2}, '0);

    // R2: mask write and read back
    wr_reg(1'b0, 32'hA5A5_0F0F);
    reg_sel = 1'b0; #1;
    chk("R2 mask readback", rd0, 32'hA5A5_0F0F);

    // R5 / R3 / R4: level-mode table
    foreach (LVL_VEC[k]) begin
      logic [N-1:0] ln, mk;
      ln = LVL_VEC[k][63:32];
      mk = LVL_VEC[k][31:0];
      wr_reg(1'b0, mk);
      irq_lines = ln;
      tick(2);
      reg_sel = 1'b1; #1;
      chk("R5 level status", rd0, ln);
      chk("R3 level irq", N'(irq0), N'(|(ln & mk)));
    end

    // R5: status write has no effect while the line stays high
    irq_lines = b(3);
    tick(1);
    wr_reg(1'b1, 32'hFFFF_FFFF);
    reg_sel = 1'b1; #1;
    chk("R5 level write ignored", rd0, b(3));

    // Edge mode
    do_reset();
    irq_lines = b(5);
    tick(2);
    reg_sel = 1'b1; #1;
    chk("R6 edge set", rd1, b(5));
    chk("R4 masked no irq", N'(irq1), '0);
    irq_lines = '0;
    tick(2);
    reg_sel = 1'b1; #1;
    chk("R6 edge hold after fall", rd1, b(5));
    wr_reg(1'b0, b(5));
    tick(1);
    chk("R3 edge irq", N'(irq1), N'(1));
    wr_reg(1'b1, 32'h0000_0000);
    reg_sel = 1'b1; #1;
    chk("R7 zero write keeps", rd1, b(5));
    wr_reg(1'b1, b(5));
    reg_sel = 1'b1; #1;
    chk("R7 one write clears", rd1, '0);
    tick(1);
    chk("R3 edge irq drops", N'(irq1), '0);
    // R8: edge and clear together
    irq_lines = b(7);
    wr_reg(1'b1, b(7));
    reg_sel = 1'b1; #1;
    chk("R8 edge wins", rd1, b(7));

    // Legacy mode
    do_reset();
    irq_lines = b(2);
    tick(1);
    irq_lines = '0;
    tick(1);
    reg_sel = 1'b1; #1;
    chk("R9 legacy latched", rd2, b(2));
    wr_reg(1'b1, 32'hFFFF_FFFF);
    reg_sel = 1'b1; #1;
    chk("R10 ones keep", rd2, b(2));
    wr_reg(1'b1, ~b(2));
    reg_sel = 1'b1; #1;
    chk("R10 zero clears", rd2, '0);
    irq_lines = b(4);
    tick(2);
    wr_reg(1'b1, ~b(4));
    reg_sel = 1'b1; #1;
    chk("R10 held line stays", rd2, b(4));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule